// File: doc/BRIEF.md
# Integer ALU with Condition-Code Register

This block is the arithmetic and logic slice of a small CPU whose operands may be 8, 16 or 32 bits wide. Each cycle it takes an operation code, a size select, two operands and an 8-bit immediate. It forms a result combinationally and raises a write-back strobe for operations that return a value. It also keeps an 8-bit flag register. That register is updated on the rising clock edge whenever the load enable is high.

The supported operations are add, subtract, compare, negate, increment, decrement, AND, OR, XOR, NOT and move. Flag byte bit 3 is negative (N), bit 2 zero (Z), bit 1 overflow (V) and bit 0 carry (C). Bits 7..4 hold the interrupt mask, a user bit, the half-carry and a second user bit. Only the direct flag operations change bits 7..4. Those operations load the flag byte from the immediate, or combine it with the immediate by AND, OR or XOR.

Opcode encoding on `opcode`: 0 add, 1 subtract, 2 compare, 3 negate, 4 increment, 5 decrement, 6 AND, 7 OR, 8 XOR, 9 NOT, 10 move, 11 flag load, 12 flag AND, 13 flag OR, 14 flag XOR, 15 no operation. Size encoding on `sizeSel`: 0 byte, 1 word, 2 long, 3 also long. Single-operand operations (negate, increment, decrement, NOT, move) act on `opA`.

Top module: `int_alu_ccr`

## Requirements
- R1: A synchronous reset clears the flag byte to 0x00.
- R2: Add (opcode 0) returns opA+opB truncated to the selected width and sets C from the carry out of that width (bit 8, 16 or 32).
- R3: For add, V is 1 exactly when both operands share a sign and the result sign differs from it.
- R4: Subtract (opcode 1) returns opA-opB in the width. C is set on unsigned borrow (opA<opB). V is 1 when the sign of opA equals the sign of the width-truncated negation of opB and the result sign differs from opA's sign.
- R5: Compare (opcode 2) updates N, Z, V and C exactly as subtract does, but `resultWe` stays low.
- R6: Negate (opcode 3) returns 0-opA. V is 1 only when opA is the most negative value of the width. C is 1 when opA is nonzero.
- R7: Increment (4) and decrement (5) step opA by 2 when opB bit 1 is set and the size is word or long, and by 1 otherwise. C keeps its previous value.
- R8: For increment and decrement, V is 1 when every bit of opA below the sign bit of the width is 1.
- R9: AND (6), OR (7), XOR (8), NOT (9, ~opA) and move (10, opA) clear V, keep C, and set N and Z from the result.
- R10: Flag load (11) writes `ccrImm` into the flag byte. Flag AND (12), flag OR (13) and flag XOR (14) combine the flag byte with `ccrImm`. None of these raises `resultWe`.
- R11: While `loadEn` is low the flag byte holds its value and `resultWe` is low, whatever the opcode.
- R12: Operations 0 to 10 leave flag bits 7..4 unchanged, and `result` is zero above the selected width.
- R13: For operations 0 to 10, N is the top bit of the width-truncated result and Z is 1 when that result is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| loadEn | input | 1 | Enables the flag update and the write-back strobe |
| opcode | input | 4 | Operation code |
| sizeSel | input | 2 | Operand width select |
| opA | input | 32 | First operand |
| opB | input | 32 | Second operand; bit 1 selects a step of 2 for increment and decrement |
| ccrImm | input | 8 | Immediate for the direct flag operations |
| result | output | 32 | Width-truncated, zero-extended result |
| resultWe | output | 1 | Result write-back strobe |
| ccrOut | output | 8 | Packed flag byte |

## Verification
Random operands drawn across all opcodes, sizes and enable values exercise the carry, borrow and overflow logic at each width. A width-select fault shows up as flags taken from the wrong bit. Directed operands sit on the sign and carry boundaries: 0x7F+1, 0xFF+1, the largest word and long values plus one, 0x80-1, negating the most negative value and zero, and incrementing 0x7F. These tell overflow apart from carry and catch a swapped rule between operation classes. Flag-immediate sequences and stretches with the enable low show that the upper flag bits move only under direct flag operations and that the flag byte truly holds.

// File: rtl/int_alu_pkg.sv
package int_alu_pkg;

  localparam int DATA_W    = 32;
  localparam int FLAG_W    = 8;
  localparam int NUM_SIZES = 3;
  localparam int MIN_W     = 8;

  typedef enum logic [3:0] {
    OP_ADD   = 4'd0,
    OP_SUB   = 4'd1,
    OP_CMP   = 4'd2,
    OP_NEG   = 4'd3,
    OP_INC   = 4'd4,
    OP_DEC   = 4'd5,
    OP_AND   = 4'd6,
    OP_OR    = 4'd7,
    OP_XOR   = 4'd8,
    OP_NOT   = 4'd9,
    OP_MOV   = 4'd10,
    OP_CCLD  = 4'd11,
    OP_CCAND = 4'd12,
    OP_CCOR  = 4'd13,
    OP_CCXOR = 4'd14,
    OP_NOP   = 4'd15
  } aluOp_e;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_WORD = 2'd1,
    SZ_LONG = 2'd2,
    SZ_LALT = 2'd3
  } aluSize_e;

  typedef enum logic [2:0] {
    Y_B, Y_NOT_B, Y_NOT_A, Y_STEP, Y_NOT_STEP
  } ySel_e;

  typedef enum logic [2:0] {
    V_ADD, V_SUB, V_NEG, V_INCDEC, V_CLEAR
  } vRule_e;

  typedef enum logic [2:0] {
    LG_AND, LG_OR, LG_XOR, LG_NOTA, LG_PASSA
  } lgSel_e;

  typedef enum logic [2:0] {
    CC_HOLD, CC_NZVC, CC_NZV, CC_LD, CC_AND, CC_OR, CC_XOR
  } ccUpd_e;

  typedef struct packed {
    logic   zeroX;
    ySel_e  ySel;
    logic   carryIn;
    logic   borrowC;
    logic   useLogic;
    lgSel_e lgSel;
    vRule_e vRule;
    ccUpd_e ccUpd;
    logic   writeRes;
  } aluStrobe_t;

endpackage

// File: rtl/int_alu_ctrl.sv
module int_alu_ctrl
  import int_alu_pkg::*;
(
  input  logic [3:0] opcode,
  output aluStrobe_t stb
);

  always_comb begin
    stb.zeroX    = 1'b0;
    stb.ySel     = Y_B;
    stb.carryIn  = 1'b0;
    stb.borrowC  = 1'b0;
    stb.useLogic = 1'b0;
    stb.lgSel    = LG_PASSA;
    stb.vRule    = V_CLEAR;
    stb.ccUpd    = CC_HOLD;
    stb.writeRes = 1'b0;
    case (aluOp_e'(opcode))
      OP_ADD: begin
        stb.vRule    = V_ADD;
        stb.ccUpd    = CC_NZVC;
        stb.writeRes = 1'b1;
      end
      OP_SUB, OP_CMP: begin
        stb.ySel     = Y_NOT_B;
        stb.carryIn  = 1'b1;
        stb.borrowC  = 1'b1;
        stb.vRule    = V_SUB;
        stb.ccUpd    = CC_NZVC;
        stb.writeRes = (aluOp_e'(opcode) == OP_SUB);
      end
      OP_NEG: begin
        stb.zeroX    = 1'b1;
        stb.ySel     = Y_NOT_A;
        stb.carryIn  = 1'b1;
        stb.borrowC  = 1'b1;
        stb.vRule    = V_NEG;
        stb.ccUpd    = CC_NZVC;
        stb.writeRes = 1'b1;
      end
      OP_INC: begin
        stb.ySel     = Y_STEP;
        stb.vRule    = V_INCDEC;
        stb.ccUpd    = CC_NZV;
        stb.writeRes = 1'b1;
      end
      OP_DEC: begin
        stb.ySel     = Y_NOT_STEP;
        stb.carryIn  = 1'b1;
        stb.vRule    = V_INCDEC;
        stb.ccUpd    = CC_NZV;
        stb.writeRes = 1'b1;
      end
      OP_AND, OP_OR, OP_XOR, OP_NOT, OP_MOV: begin
        stb.useLogic = 1'b1;
        stb.ccUpd    = CC_NZV;
        stb.writeRes = 1'b1;
        case (aluOp_e'(opcode))
          OP_AND:  stb.lgSel = LG_AND;
          OP_OR:   stb.lgSel = LG_OR;
          OP_XOR:  stb.lgSel = LG_XOR;
          OP_NOT:  stb.lgSel = LG_NOTA;
          default: stb.lgSel = LG_PASSA;
        endcase
      end
      OP_CCLD:  stb.ccUpd = CC_LD;
      OP_CCAND: stb.ccUpd = CC_AND;
      OP_CCOR:  stb.ccUpd = CC_OR;
      OP_CCXOR: stb.ccUpd = CC_XOR;
      default:  stb.ccUpd = CC_HOLD;
    endcase
  end

endmodule

// File: rtl/int_alu_slice.sv
module int_alu_slice
  import int_alu_pkg::*;
#(
  parameter int W = 8
) (
  input  logic [W-1:0] opA,
  input  logic [W-1:0] opB,
  input  logic [W-1:0] xOp,
  input  logic [W-1:0] yOp,
  input  logic [W-1:0] lgRes,
  input  logic         carryIn,
  input  logic         borrowC,
  input  logic         useLogic,
  input  vRule_e       vRule,
  output logic [W-1:0] res,
  output logic [3:0]   flags
);

  localparam int SIGN = W - 1;

  logic [W:0]   sumExt;
  logic [W-1:0] negB;
  logic         ovf;
  logic         carryBit;

  assign sumExt   = {1'b0, xOp} + {1'b0, yOp} + {{W{1'b0}}, carryIn};
  assign negB     = (~opB) + {{(W-1){1'b0}}, 1'b1};
  assign res      = useLogic ? lgRes : sumExt[W-1:0];
  assign carryBit = borrowC ? ~sumExt[W] : sumExt[W];

  always_comb begin
    case (vRule)
      V_ADD:    ovf = (opA[SIGN] == opB[SIGN]) && (res[SIGN] != opA[SIGN]);
      V_SUB:    ovf = (opA[SIGN] == negB[SIGN]) && (res[SIGN] != opA[SIGN]);
      V_NEG:    ovf = opA[SIGN] && (opA[SIGN-1:0] == '0);
      V_INCDEC: ovf = &opA[SIGN-1:0];
      default:  ovf = 1'b0;
    endcase
  end

  assign flags = {res[SIGN], (res == '0), ovf, carryBit};

endmodule

// File: rtl/int_alu_datapath.sv
module int_alu_datapath
  import int_alu_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              loadEn,
  input  aluStrobe_t        stb,
  input  logic [1:0]        sizeSel,
  input  logic [DATA_W-1:0] opA,
  input  logic [DATA_W-1:0] opB,
  input  logic [FLAG_W-1:0] ccrImm,
  output logic [DATA_W-1:0] result,
  output logic [FLAG_W-1:0] ccrQ
);

  logic [DATA_W-1:0] xOp;
  logic [DATA_W-1:0] yOp;
  logic [DATA_W-1:0] stepVal;
  logic [DATA_W-1:0] lgRes;
  logic [DATA_W-1:0] resArr  [NUM_SIZES];
  logic [3:0]        flagArr [NUM_SIZES];
  logic [1:0]        sizeIdx;
  logic [3:0]        flagSel;
  logic [FLAG_W-1:0] ccrNext;

  assign stepVal = (opB[1] && (aluSize_e'(sizeSel) != SZ_BYTE)) ? DATA_W'(2) : DATA_W'(1);
  assign xOp     = stb.zeroX ? '0 : opA;

  always_comb begin
    case (stb.ySel)
      Y_B:        yOp = opB;
      Y_NOT_B:    yOp = ~opB;
      Y_NOT_A:    yOp = ~opA;
      Y_STEP:     yOp = stepVal;
      Y_NOT_STEP: yOp = ~stepVal;
      default:    yOp = '0;
    endcase
  end

  always_comb begin
    case (stb.lgSel)
      LG_AND:  lgRes = opA & opB;
      LG_OR:   lgRes = opA | opB;
      LG_XOR:  lgRes = opA ^ opB;
      LG_NOTA: lgRes = ~opA;
      default: lgRes = opA;
    endcase
  end

  for (genvar k = 0; k < NUM_SIZES; k++) begin : g_width
    localparam int W = MIN_W << k;
    logic [W-1:0] sliceRes;
    int_alu_slice #(.W(W)) u_slice (
      .opA      (opA[W-1:0]),
      .opB      (opB[W-1:0]),
      .xOp      (xOp[W-1:0]),
      .yOp      (yOp[W-1:0]),
      .lgRes    (lgRes[W-1:0]),
      .carryIn  (stb.carryIn),
      .borrowC  (stb.borrowC),
      .useLogic (stb.useLogic),
      .vRule    (stb.vRule),
      .res      (sliceRes),
      .flags    (flagArr[k])
    );
    assign resArr[k] = DATA_W'(sliceRes);
  end

  always_comb begin
    case (aluSize_e'(sizeSel))
      SZ_BYTE: sizeIdx = 2'd0;
      SZ_WORD: sizeIdx = 2'd1;
      default: sizeIdx = 2'd2;
    endcase
  end

  assign flagSel = flagArr[sizeIdx];
  assign result  = resArr[sizeIdx];

  always_comb begin
    ccrNext = ccrQ;
    if (loadEn) begin
      case (stb.ccUpd)
        CC_NZVC: ccrNext[3:0] = flagSel;
        CC_NZV:  ccrNext[3:1] = flagSel[3:1];
        CC_LD:   ccrNext      = ccrImm;
        CC_AND:  ccrNext      = ccrQ & ccrImm;
        CC_OR:   ccrNext      = ccrQ | ccrImm;
        CC_XOR:  ccrNext      = ccrQ ^ ccrImm;
        default: ccrNext      = ccrQ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) ccrQ <= '0;
    else     ccrQ <= ccrNext;
  end

endmodule

// File: rtl/int_alu_ccr.sv
module int_alu_ccr
  import int_alu_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              loadEn,
  input  logic [3:0]        opcode,
  input  logic [1:0]        sizeSel,
  input  logic [DATA_W-1:0] opA,
  input  logic [DATA_W-1:0] opB,
  input  logic [FLAG_W-1:0] ccrImm,
  output logic [DATA_W-1:0] result,
  output logic              resultWe,
  output logic [FLAG_W-1:0] ccrOut
);

  aluStrobe_t stb;

  int_alu_ctrl u_ctrl (
    .opcode (opcode),
    .stb    (stb)
  );

  int_alu_datapath u_dp (
    .clk     (clk),
    .rst     (rst),
    .loadEn  (loadEn),
    .stb     (stb),
    .sizeSel (sizeSel),
    .opA     (opA),
    .opB     (opB),
    .ccrImm  (ccrImm),
    .result  (result),
    .ccrQ    (ccrOut)
  );

  assign resultWe = loadEn && stb.writeRes;

endmodule

// File: rtl/int_alu_ccr_chk.sv
module int_alu_ccr_chk
  import int_alu_pkg::*;
(
  input logic              clk,
  input logic              rst,
  input logic              loadEn,
  input logic [3:0]        opcode,
  input logic [1:0]        sizeSel,
  input logic [DATA_W-1:0] result,
  input logic              resultWe,
  input logic [FLAG_W-1:0] ccrOut
);

  logic seenClk = 1'b0;
  always_ff @(posedge clk) seenClk <= 1'b1;

  logic aluClass;
  logic incDec;
  logic logicOp;
  assign aluClass = (opcode <= 4'd10);
  assign incDec   = (opcode == 4'd4) || (opcode == 4'd5);
  assign logicOp  = (opcode >= 4'd6) && (opcode <= 4'd10);

  AST_RESET_CLEAR: assert property (@(posedge clk)
    seenClk && $past(rst) |-> ccrOut == 8'h00); // R1

  AST_CMP_NO_WB: assert property (@(posedge clk) disable iff (rst)
    opcode == 4'd2 |-> !resultWe); // R5

  AST_INCDEC_CARRY: assert property (@(posedge clk) disable iff (rst)
    seenClk && !$past(rst) && $past(loadEn) && $past(incDec)
    |-> ccrOut[0] == $past(ccrOut[0])); // R7

  AST_LOGIC_V_CLEAR: assert property (@(posedge clk) disable iff (rst)
    seenClk && !$past(rst) && $past(loadEn) && $past(logicOp)
    |-> !ccrOut[1]); // R9

  AST_HOLD_NO_LOAD: assert property (@(posedge clk) disable iff (rst)
    seenClk && !$past(rst) && !$past(loadEn) |-> $stable(ccrOut)); // R11

  AST_NO_WB_NO_LOAD: assert property (@(posedge clk) disable iff (rst)
    !loadEn |-> !resultWe); // R11

  AST_UPPER_KEEP: assert property (@(posedge clk) disable iff (rst)
    seenClk && !$past(rst) && $past(loadEn) && $past(aluClass)
    |-> ccrOut[7:4] == $past(ccrOut[7:4])); // R12

  AST_BYTE_ZERO_EXT: assert property (@(posedge clk) disable iff (rst)
    sizeSel == 2'd0 |-> result[31:8] == 24'h0); // R12

  AST_ZERO_FLAG: assert property (@(posedge clk) disable iff (rst)
    seenClk && !$past(rst) && $past(loadEn) && $past(aluClass)
    |-> ccrOut[2] == ($past(result) == '0)); // R13

endmodule

bind int_alu_ccr int_alu_ccr_chk u_chk (
  .clk      (clk),
  .rst      (rst),
  .loadEn   (loadEn),
  .opcode   (opcode),
  .sizeSel  (sizeSel),
  .result   (result),
  .resultWe (resultWe),
  .ccrOut   (ccrOut)
);

// File: tb/int_alu_ccr_bench.sv
module int_alu_ccr_bench;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        loadEn = 1'b0;
  logic [3:0]  opcode = 4'd15;
  logic [1:0]  sizeSel = 2'd0;
  logic [31:0] opA = '0;
  logic [31:0] opB = '0;
  logic [7:0]  ccrImm = '0;
  logic [31:0] result;
  logic        resultWe;
  logic [7:0]  ccrOut;

  int checks = 0;
  int fails  = 0;
  logic [7:0] modelCcr = 8'h00;

  always #5 clk = ~clk;

  int_alu_ccr u_int_alu_ccr (
    .clk(clk), .rst(rst), .loadEn(loadEn), .opcode(opcode), .sizeSel(sizeSel),
    .opA(opA), .opB(opB), .ccrImm(ccrImm),
    .result(result), .resultWe(resultWe), .ccrOut(ccrOut)
  );

  task automatic check(input string req, input string what,
                       input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s %s: got %h expected %h", req, what, got, exp);
    end
  endtask

  function automatic string reqFor(input logic [3:0] op);
    case (op)
      4'd0:                   return "R2";
      4'd1:                   return "R4";
      4'd2:                   return "R5";
      4'd3:                   return "R6";
      4'd4, 4'd5:             return "R7";
      4'd6, 4'd7, 4'd8, 4'd9, 4'd10: return "R9";
      4'd15:                  return "R11";
      default:                return "R10";
    endcase
  endfunction

  function automatic void model(
    input  logic [3:0]  op, input logic [1:0] sz, input logic en,
    input  logic [31:0] a,  input logic [31:0] b, input logic [7:0] imm,
    input  logic [7:0]  ccrIn,
    output logic [31:0] res, output logic we, output logic [7:0] ccrNew);
    int w;
    logic [63:0] mask, sgn, am, bm, full, nb, r;
    logic n, z, v, c, upd;
    w    = (sz == 2'd0) ? 8 : (sz == 2'd1) ? 16 : 32;
    mask = (64'd1 << w) - 64'd1;
    sgn  = 64'd1 << (w - 1);
    am   = {32'd0, a} & mask;
    bm   = {32'd0, b} & mask;
    c    = ccrIn[0];
    v    = 1'b0;
    r    = 64'd0;
    upd  = 1'b1;
    we   = 1'b0;
    ccrNew = ccrIn;
    case (op)
      4'd0: begin
        full = am + bm; r = full & mask; c = full[w];
        v = ((am & sgn) == (bm & sgn)) && ((r & sgn) != (am & sgn)); we = 1'b1;
      end
      4'd1, 4'd2: begin
        r = (am - bm) & mask; c = (am < bm); nb = (64'd0 - bm) & mask;
        v = ((am & sgn) == (nb & sgn)) && ((r & sgn) != (am & sgn));
        we = (op == 4'd1);
      end
      4'd3: begin
        r = (64'd0 - am) & mask; c = (am != 0); v = (am == sgn); we = 1'b1;
      end
      4'd4, 4'd5: begin
        full = (sz != 2'd0 && b[1]) ? 64'd2 : 64'd1;
        r = ((op == 4'd4) ? am + full : am - full) & mask;
        v = ((am & (sgn - 64'd1)) == (sgn - 64'd1)); we = 1'b1;
      end
      4'd6:  begin r = am & bm; we = 1'b1; end
      4'd7:  begin r = am | bm; we = 1'b1; end
      4'd8:  begin r = am ^ bm; we = 1'b1; end
      4'd9:  begin r = (~am) & mask; we = 1'b1; end
      4'd10: begin r = am; we = 1'b1; end
      default: upd = 1'b0;
    endcase
    n = (r & sgn) != 0;
    z = (r == 0);
    res = r[31:0];
    if (!en) begin
      we = 1'b0;
    end else if (upd) begin
      ccrNew = {ccrIn[7:4], n, z, v, c};
    end else begin
      case (op)
        4'd11: ccrNew = imm;
        4'd12: ccrNew = ccrIn & imm;
        4'd13: ccrNew = ccrIn | imm;
        4'd14: ccrNew = ccrIn ^ imm;
        default: ccrNew = ccrIn;
      endcase
    end
  endfunction

  task automatic runOp(input logic [3:0] op, input logic [1:0] sz, input logic en,
                       input logic [31:0] a, input logic [31:0] b, input logic [7:0] imm,
                       input string req);
    logic [31:0] expRes;
    logic        expWe;
    logic [7:0]  expCcr;
    string tag;
    tag = (req == "") ? reqFor(op) : req;
    @(negedge clk);
    opcode = op; sizeSel = sz; loadEn = en; opA = a; opB = b; ccrImm = imm;
    model(op, sz, en, a, b, imm, modelCcr, expRes, expWe, expCcr);
    #2;
    check(tag, "resultWe", {31'd0, resultWe}, {31'd0, expWe});
    if (expWe) check(tag, "result", result, expRes);
    @(posedge clk);
    #1;
    check(tag, "ccr", {24'd0, ccrOut}, {24'd0, expCcr});
    modelCcr = expCcr;
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin : stim
    void'($urandom(32'h5eed_1234));
    repeat (3) @(posedge clk);
    #1;
    check("R1", "ccr after reset", {24'd0, ccrOut}, 32'h0);
    check("R11", "we idle", {31'd0, resultWe}, 32'h0);
    @(negedge clk);
    rst = 1'b0;

    // R2 / R3 directed add corners
    runOp(4'd0, 2'd0, 1'b1, 32'h7F, 32'h01, 8'h00, "R3");
    runOp(4'd0, 2'd0, 1'b1, 32'hFF, 32'h01, 8'h00, "R2");
    runOp(4'd0, 2'd1, 1'b1, 32'hFFFF, 32'h1, 8'h00, "R2");
    runOp(4'd0, 2'd2, 1'b1, 32'hFFFF_FFFF, 32'h1, 8'h00, "R2");
    runOp(4'd0, 2'd0, 1'b1, 32'h80, 32'h80, 8'h00, "R3");
    // R4 / R5 subtract and compare
    runOp(4'd1, 2'd0, 1'b1, 32'h80, 32'h01, 8'h00, "R4");
    runOp(4'd1, 2'd1, 1'b1, 32'h0000, 32'h8000, 8'h00, "R4");
    runOp(4'd2, 2'd0, 1'b1, 32'h05, 32'h07, 8'h00, "R5");
    // R6 negate
    runOp(4'd3, 2'd0, 1'b1, 32'h80, 32'h0, 8'h00, "R6");
    runOp(4'd3, 2'd2, 1'b1, 32'h0, 32'h0, 8'h00, "R6");
    // R7 / R8 increment and decrement
    runOp(4'd10, 2'd0, 1'b1, 32'h0, 32'h0, 8'h00, "R13");
    runOp(4'd4, 2'd0, 1'b1, 32'h7F, 32'h2, 8'h00, "R8");
    runOp(4'd5, 2'd1, 1'b1, 32'h0001, 32'h2, 8'h00, "R7");
    runOp(4'd4, 2'd2, 1'b1, 32'h7FFF_FFFF, 32'h2, 8'h00, "R8");
    // R9 logic with zero result
    runOp(4'd6, 2'd1, 1'b1, 32'hF0F0, 32'h0F0F, 8'h00, "R9");
    // R10 direct flag operations, then R12 upper bits kept
    runOp(4'd11, 2'd0, 1'b1, 32'h0, 32'h0, 8'hF5, "R10");
    runOp(4'd12, 2'd0, 1'b1, 32'h0, 32'h0, 8'hA3, "R10");
    runOp(4'd13, 2'd0, 1'b1, 32'h0, 32'h0, 8'h48, "R10");
    runOp(4'd14, 2'd0, 1'b1, 32'h0, 32'h0, 8'hFF, "R10");
    runOp(4'd11, 2'd0, 1'b1, 32'h0, 32'h0, 8'hD0, "R10");
    runOp(4'd0, 2'd0, 1'b1, 32'h1234_5680, 32'h10, 8'h00, "R12");
    // R11 enable low: flags held, no write-back
    runOp(4'd0, 2'd0, 1'b0, 32'hFF, 32'h01, 8'h00, "R11");
    runOp(4'd11, 2'd0, 1'b0, 32'h0, 32'h0, 8'h00, "R11");

    for (int i = 0; i < 3000; i++) begin
      logic [3:0] op;
      logic [1:0] sz;
      logic en;
      op = 4'($urandom_range(0, 15));
      sz = 2'($urandom_range(0, 3));
      en = ($urandom_range(0, 9) != 0);
      runOp(op, sz, en, $urandom, $urandom, 8'($urandom), "");
    end

    @(negedge clk);
    rst = 1'b1; loadEn = 1'b0;
    @(posedge clk);
    #1;
    check("R1", "ccr after second reset", {24'd0, ccrOut}, 32'h0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule